// File: doc/BRIEF.md
# Debug-port target bring-up sequencer

This block sits on the host side of a production programmer. It walks a target microcontroller through a fixed bring-up order before any flash work starts. The order is: hold the interface-select strap, hold the target in reset, confirm the link by reading an identification register, and wait for the flash to report ready. It then stops if the part is secured. Otherwise it requests a debug halt so that the core cannot boot, and finally lets the target out of reset. All register traffic goes through an abstract register-access port. That port uses a request/acknowledge handshake and returns read data. The serial wire layer behind it is not part of this block.

A one-cycle `start` pulse launches the sequence. A one-cycle `done` pulse reports one of four outcomes on `result`:
- ok: the target is halted and out of reset.
- secured: the target is still held in reset and no halt was requested.
- timeout: some step did not finish within the programmed cycle budget.
- id-error: the identification value did not match.

A build-time parameter selects how the target reset is driven. It can use a dedicated reset pin. For targets without one, it can use a system-reset-request bit in the target's control register.

Top module: `dbg_connect_seq`

## Requirements
- R1: `strap_sel` is driven to `STRAP_LEVEL` (default 1, which selects the debug-port pin functions) from reset onward and never changes.
- R2: In pin mode (`USE_RST_PIN`=1), `tgt_rst_n` goes low when a sequence starts, before the first request. It is low during every request. It only returns high after the halt request write has been acknowledged.
- R3: The first transaction of every sequence is a read of address `ID_ADDR` (default 0x00). If the data differs from `EXPECT_ID`, the sequence ends with result 3 (id-error) and the status register is never read.
- R4: The status register at `STAT_ADDR` (default 0x04) is read again and again until bit 1 (flash ready) reads 1. On success the number of status reads is one more than the number of not-ready replies.
- R5: If bit 2 (secured) of the first ready status word is 1, the sequence ends with result 1 (secured). No control write with the halt bit set is made, and the target stays in reset.
- R6: If that bit is 0, the block writes the control register at `CTRL_ADDR` (default 0x08) with bit 2 (debug halt) set. It then releases reset and ends with result 0 (ok).
- R7: In register-reset mode (`USE_RST_PIN`=0), a control write with bit 3 (system reset request) set follows the ID check and precedes every status read. The halt write keeps bit 3 set. Release is a further control write with bit 2 set and bit 3 clear.
- R8: If any step stays in one state for `tmo_limit` cycles, the sequence ends with result 2 (timeout) and the pending request is withdrawn. The poll loop counts as one step across all of its re-reads.
- R9: `done` is high for exactly one cycle per sequence. `result` holds its value until the next sequence ends. A `start` pulse during a sequence is ignored.
- R10: Once `dp_req` rises, it stays high with `dp_addr`, `dp_we` and `dp_wdata` stable until the cycle in which `dp_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a sequence |
| tmo_limit | input | TMO_W | Cycle budget per step |
| tgt_rst_n | output | 1 | Active-low target reset line (pin mode) |
| strap_sel | output | 1 | Interface-select strap level |
| dp_req | output | 1 | Register access request |
| dp_we | output | 1 | 1 = write, 0 = read |
| dp_addr | output | AW | Register address |
| dp_wdata | output | DW | Write data |
| dp_ack | input | 1 | One-cycle acknowledge of the pending request |
| dp_rdata | input | DW | Read data, valid with `dp_ack` |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 secured, 2 timeout, 3 id-error |

## Verification
A wrong internal state in this block shows up at the ports as a step out of order. Examples are a status read seen while the target is out of reset, a halt write on a secured part, or a missing reset-request write. A mismatch is visible on the request bus within one transaction of the step that went wrong. An error in the outcome logic shows on `result` in the cycle `done` pulses, while the target reset level afterwards shows whether the release step was taken. A stuck sequence can only be seen through the timeout outcome, which appears no later than `tmo_limit` plus two cycles after the step began.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_SECURED = 2'd1,
    RES_TIMEOUT = 2'd2,
    RES_IDERR   = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ID,
    ST_SRR_ON,
    ST_POLL,
    ST_HALT,
    ST_REL
  } seq_st_e;
endpackage

// File: rtl/dbg_step_timer.sv
module dbg_step_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  assign expired = !clr && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dbg_xact_eng.sv
module dbg_xact_eng #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  input  logic          abort,
  output logic          req,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  input  logic          ack,
  input  logic [DW-1:0] rdata,
  output logic          fin,
  output logic [DW-1:0] fin_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req      <= 1'b0;
      we       <= 1'b0;
      addr     <= '0;
      wdata    <= '0;
      fin      <= 1'b0;
      fin_data <= '0;
    end else begin
      fin <= 1'b0;
      if (abort) begin
        req <= 1'b0;
      end else if (req && ack) begin
        req      <= 1'b0;
        fin      <= 1'b1;
        fin_data <= rdata;
      end else if (go && !req) begin
        req   <= 1'b1;
        we    <= go_we;
        addr  <= go_addr;
        wdata <= go_wdata;
      end
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !ack && !abort) |=> req);
  // R10
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !ack && !abort) |=> ($stable(addr) && $stable(we) && $stable(wdata)));
endmodule

// File: rtl/dbg_connect_seq.sv
module dbg_connect_seq
  import dbg_seq_pkg::*;
#(
  parameter int          AW            = 8,
  parameter int          DW            = 32,
  parameter int          TMO_W         = 16,
  parameter bit          USE_RST_PIN   = 1'b1,
  parameter bit          STRAP_LEVEL   = 1'b1,
  parameter logic [DW-1:0] EXPECT_ID   = 32'h5A17_C0DE,
  parameter logic [AW-1:0] ID_ADDR     = 8'h00,
  parameter logic [AW-1:0] STAT_ADDR   = 8'h04,
  parameter logic [AW-1:0] CTRL_ADDR   = 8'h08,
  parameter int          STAT_RDY_BIT  = 1,
  parameter int          STAT_SEC_BIT  = 2,
  parameter int          CTRL_HALT_BIT = 2,
  parameter int          CTRL_SRR_BIT  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             tgt_rst_n,
  output logic             strap_sel,
  output logic             dp_req,
  output logic             dp_we,
  output logic [AW-1:0]    dp_addr,
  output logic [DW-1:0]    dp_wdata,
  input  logic             dp_ack,
  input  logic [DW-1:0]    dp_rdata,
  output logic             done,
  output logic [1:0]       result
);
  localparam logic [DW-1:0] HALT_MASK = DW'(1) << CTRL_HALT_BIT;
  localparam logic [DW-1:0] SRR_MASK  = DW'(1) << CTRL_SRR_BIT;
  localparam logic [DW-1:0] HALT_WORD = USE_RST_PIN ? HALT_MASK : (HALT_MASK | SRR_MASK);

  seq_st_e       state, st_prev;
  logic          issued;
  logic          go, go_we;
  logic [AW-1:0] go_addr;
  logic [DW-1:0] go_wdata;
  logic          eng_fin;
  logic [DW-1:0] fin_data;
  logic          tmo_exp, tmo_clr, abort;

  // transaction issued by each step
  always_comb begin
    go_we    = 1'b0;
    go_addr  = ID_ADDR;
    go_wdata = '0;
    unique case (state)
      ST_SRR_ON: begin go_we = 1'b1; go_addr = CTRL_ADDR; go_wdata = SRR_MASK;  end
      ST_POLL:   begin go_addr = STAT_ADDR; end
      ST_HALT:   begin go_we = 1'b1; go_addr = CTRL_ADDR; go_wdata = HALT_WORD; end
      ST_REL:    begin go_we = 1'b1; go_addr = CTRL_ADDR; go_wdata = HALT_MASK; end
      default:   ;
    endcase
  end

  assign go      = (state != ST_IDLE) && !issued && !tmo_exp;
  assign tmo_clr = (state != st_prev) || (state == ST_IDLE);
  assign abort   = (state != ST_IDLE) && tmo_exp && !eng_fin;

  dbg_step_timer #(.W(TMO_W)) u_timer (
    .clk(clk), .rst(rst), .clr(tmo_clr), .en(state != ST_IDLE),
    .limit(tmo_limit), .expired(tmo_exp)
  );

  dbg_xact_eng #(.AW(AW), .DW(DW)) u_eng (
    .clk(clk), .rst(rst), .go(go), .go_we(go_we), .go_addr(go_addr),
    .go_wdata(go_wdata), .abort(abort), .req(dp_req), .we(dp_we),
    .addr(dp_addr), .wdata(dp_wdata), .ack(dp_ack), .rdata(dp_rdata),
    .fin(eng_fin), .fin_data(fin_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      st_prev   <= ST_IDLE;
      issued    <= 1'b0;
      tgt_rst_n <= 1'b1;
      strap_sel <= STRAP_LEVEL;
      done      <= 1'b0;
      result    <= RES_OK;
    end else begin
      st_prev <= state;
      done    <= 1'b0;
      if (go) issued <= 1'b1;
      if (state == ST_IDLE) begin
        issued <= 1'b0;
        if (start) begin
          state <= ST_RD_ID;
          if (USE_RST_PIN) tgt_rst_n <= 1'b0;
        end
      end else if (eng_fin) begin
        issued <= 1'b0;
        unique case (state)
          ST_RD_ID:
            if (fin_data != EXPECT_ID) begin
              done <= 1'b1; result <= RES_IDERR; state <= ST_IDLE;
            end else begin
              state <= USE_RST_PIN ? ST_POLL : ST_SRR_ON;
            end
          ST_SRR_ON: state <= ST_POLL;
          ST_POLL:
            if (fin_data[STAT_RDY_BIT]) begin
              if (fin_data[STAT_SEC_BIT]) begin
                done <= 1'b1; result <= RES_SECURED; state <= ST_IDLE;
              end else begin
                state <= ST_HALT;
              end
            end
          ST_HALT:
            if (USE_RST_PIN) begin
              tgt_rst_n <= 1'b1;
              done <= 1'b1; result <= RES_OK; state <= ST_IDLE;
            end else begin
              state <= ST_REL;
            end
          ST_REL: begin
            done <= 1'b1; result <= RES_OK; state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end else if (tmo_exp) begin
        done <= 1'b1; result <= RES_TIMEOUT; state <= ST_IDLE;
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5
  secured_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POLL && eng_fin && fin_data[STAT_RDY_BIT] && fin_data[STAT_SEC_BIT])
    |=> (done && result == RES_SECURED && !dp_req));
  // R8
  timeout_end_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && tmo_exp && !eng_fin) |=> (done && result == RES_TIMEOUT && !dp_req));
  // R1
  strap_level_chk: assert property (@(posedge clk) disable iff (rst)
    strap_sel == STRAP_LEVEL);

  generate
    if (USE_RST_PIN) begin : g_pin_chk
      // R2
      req_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        dp_req |-> !tgt_rst_n);
    end
  endgenerate
endmodule

// File: tb/tb_dbg_connect_seq.sv
module tb_target (
  input  logic        clk,
  input  logic        clr,
  input  logic        rst_n_pin,
  input  logic        req,
  input  logic        we,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata,
  input  logic [31:0] cfg_id,
  input  logic [7:0]  cfg_rdy,
  input  logic        cfg_sec,
  input  logic [3:0]  cfg_lat,
  input  logic        cfg_stall,
  output logic [15:0] id_reads,
  output logic [15:0] st_reads,
  output logic [15:0] bad_reads,
  output logic        halt_wr,
  output logic        halt_in_rst,
  output logic        in_reset
);
  logic       srr;
  logic [3:0] wcnt;
  assign in_reset = !rst_n_pin || srr;

  always @(posedge clk) begin
    if (clr) begin
      ack <= 0; rdata <= 0; srr <= 0; wcnt <= 0;
      id_reads <= 0; st_reads <= 0; bad_reads <= 0;
      halt_wr <= 0; halt_in_rst <= 0;
    end else if (ack) begin
      ack <= 0;
    end else if (req && !cfg_stall) begin
      if (wcnt == cfg_lat) begin
        ack  <= 1;
        wcnt <= 0;
        if (we) begin
          if (addr == 8'h08) begin
            srr <= wdata[3];
            if (wdata[2] && !halt_wr) begin
              halt_wr     <= 1;
              halt_in_rst <= in_reset;
            end
          end
        end else if (addr == 8'h00) begin
          id_reads <= id_reads + 1;
          rdata    <= cfg_id;
        end else if (addr == 8'h04) begin
          st_reads <= st_reads + 1;
          if (!in_reset) bad_reads <= bad_reads + 1;
          rdata <= {29'd0, cfg_sec, (st_reads >= {8'd0, cfg_rdy}), 1'b0};
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end
endmodule

module tb_dbg_connect_seq;
  typedef struct packed {
    logic [31:0] id;
    logic [7:0]  rdy;
    logic        sec;
    logic [3:0]  lat;
    logic        stall;
    logic [1:0]  exp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{32'h5A17_C0DE, 8'd0,   1'b0, 4'd0, 1'b0, 2'd0},
    '{32'h5A17_C0DE, 8'd3,   1'b0, 4'd2, 1'b0, 2'd0},
    '{32'h5A17_C0DE, 8'd1,   1'b1, 4'd1, 1'b0, 2'd1},
    '{32'h1234_5678, 8'd0,   1'b0, 4'd0, 1'b0, 2'd3},
    '{32'h5A17_C0DE, 8'd255, 1'b0, 4'd0, 1'b0, 2'd2},
    '{32'h5A17_C0DE, 8'd0,   1'b0, 4'd0, 1'b1, 2'd2}
  };

  logic clk = 0;
  always #10 clk = ~clk;

  logic rst = 1, start = 0, mclr = 1;
  logic [15:0] tmo_limit = 16'd200;
  logic [31:0] cfg_id = 0;
  logic [7:0]  cfg_rdy = 0;
  logic        cfg_sec = 0, cfg_stall = 0;
  logic [3:0]  cfg_lat = 0;

  logic a_rst_n, a_strap, a_req, a_we, a_ack, a_done;
  logic [7:0] a_addr; logic [31:0] a_wdata, a_rdata; logic [1:0] a_res;
  logic b_rst_n, b_strap, b_req, b_we, b_ack, b_done;
  logic [7:0] b_addr; logic [31:0] b_wdata, b_rdata; logic [1:0] b_res;

  dbg_connect_seq #(.USE_RST_PIN(1'b1)) dut (
    .clk(clk), .rst(rst), .start(start), .tmo_limit(tmo_limit),
    .tgt_rst_n(a_rst_n), .strap_sel(a_strap), .dp_req(a_req), .dp_we(a_we),
    .dp_addr(a_addr), .dp_wdata(a_wdata), .dp_ack(a_ack), .dp_rdata(a_rdata),
    .done(a_done), .result(a_res));

  dbg_connect_seq #(.USE_RST_PIN(1'b0)) dut_np (
    .clk(clk), .rst(rst), .start(start), .tmo_limit(tmo_limit),
    .tgt_rst_n(b_rst_n), .strap_sel(b_strap), .dp_req(b_req), .dp_we(b_we),
    .dp_addr(b_addr), .dp_wdata(b_wdata), .dp_ack(b_ack), .dp_rdata(b_rdata),
    .done(b_done), .result(b_res));

  logic [15:0] a_idr, a_str, a_bad, b_idr, b_str, b_bad;
  logic a_hw, a_hir, a_inr, b_hw, b_hir, b_inr;

  tb_target tgt_a (.clk(clk), .clr(mclr), .rst_n_pin(a_rst_n), .req(a_req), .we(a_we),
    .addr(a_addr), .wdata(a_wdata), .ack(a_ack), .rdata(a_rdata), .cfg_id(cfg_id),
    .cfg_rdy(cfg_rdy), .cfg_sec(cfg_sec), .cfg_lat(cfg_lat), .cfg_stall(cfg_stall),
    .id_reads(a_idr), .st_reads(a_str), .bad_reads(a_bad), .halt_wr(a_hw),
    .halt_in_rst(a_hir), .in_reset(a_inr));
  tb_target tgt_b (.clk(clk), .clr(mclr), .rst_n_pin(b_rst_n), .req(b_req), .we(b_we),
    .addr(b_addr), .wdata(b_wdata), .ack(b_ack), .rdata(b_rdata), .cfg_id(cfg_id),
    .cfg_rdy(cfg_rdy), .cfg_sec(cfg_sec), .cfg_lat(cfg_lat), .cfg_stall(cfg_stall),
    .id_reads(b_idr), .st_reads(b_str), .bad_reads(b_bad), .halt_wr(b_hw),
    .halt_in_rst(b_hir), .in_reset(b_inr));

  int errors = 0, checks = 0;
  int a_dcnt = 0, b_dcnt = 0;
  logic [1:0] a_cap = 0, b_cap = 0;
  logic strap_bad = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (mclr) begin
      a_dcnt <= 0; b_dcnt <= 0;
    end else begin
      if (a_done) begin a_dcnt <= a_dcnt + 1; a_cap <= a_res; end
      if (b_done) begin b_dcnt <= b_dcnt + 1; b_cap <= b_res; end
    end
    if (!rst && (a_strap !== 1'b1 || b_strap !== 1'b1)) strap_bad <= 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic run_vec(input int i);
    vec_t v = VEC[i];
    @(negedge clk);
    cfg_id = v.id; cfg_rdy = v.rdy; cfg_sec = v.sec; cfg_lat = v.lat; cfg_stall = v.stall;
    mclr = 1;
    @(negedge clk);
    mclr = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (2) @(negedge clk);
    start = 1;                          // R9: ignored while busy
    @(negedge clk);
    start = 0;
    for (int w = 0; w < 3000 && !(a_dcnt > 0 && b_dcnt > 0); w++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(a_dcnt == 1, "R9 pin done pulse count", a_dcnt, 1);
    chk(b_dcnt == 1, "R9 reg done pulse count", b_dcnt, 1);
    chk(a_cap == v.exp, "R3/R5/R6/R8 pin result", a_cap, v.exp);
    chk(b_cap == v.exp, "R7/R8 reg result", b_cap, v.exp);
    chk(a_res == a_cap, "R9 pin result held", a_res, a_cap);
    chk(a_idr == 1 || (v.stall && a_idr == 0), "R3 R9 single ID read", a_idr, 1);
    chk(a_bad == 0, "R2 pin status reads in reset", a_bad, 0);
    chk(b_bad == 0, "R7 reg status reads in reset", b_bad, 0);
    chk(a_hw == (v.exp == 2'd0), "R5 R6 pin halt write", a_hw, v.exp == 2'd0);
    chk(b_hw == (v.exp == 2'd0), "R5 R7 reg halt write", b_hw, v.exp == 2'd0);
    chk(!a_req && !b_req, "R8 request withdrawn", a_req, 0);
    if (v.exp == 2'd3) chk(a_str == 0, "R3 no status read after id-error", a_str, 0);
    if (v.exp == 2'd0) begin
      chk(a_str == v.rdy + 1, "R4 status read count", a_str, v.rdy + 1);
      chk(a_hir && b_hir, "R6 R7 halt written in reset", a_hir, 1);
      chk(!a_inr, "R6 pin reset released", a_inr, 0);
      chk(!b_inr, "R7 reg reset released", b_inr, 0);
    end
    if (v.exp == 2'd1) begin
      chk(a_inr, "R5 pin held in reset", a_inr, 1);
      chk(b_inr, "R5 reg held in reset", b_inr, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(a_rst_n == 1, "reset state tgt_rst_n", a_rst_n, 1);
    chk(a_strap == 1 && b_strap == 1, "R1 strap after reset", a_strap, 1);
    chk(!a_done && !a_req && a_res == 0, "reset state done/req/result", a_done, 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R10: stalled request stays up; R2 reset held during it
    @(negedge clk);
    cfg_id = 32'h5A17_C0DE; cfg_stall = 1; tmo_limit = 16'd100;
    mclr = 1; @(negedge clk); mclr = 0;
    start = 1; @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    chk(a_req == 1 && a_addr == 8'h00, "R10 request held while unacked", a_req, 1);
    chk(a_rst_n == 0, "R2 reset low during request", a_rst_n, 1'b0);
    for (int w = 0; w < 500 && a_dcnt == 0; w++) @(negedge clk);
    chk(a_cap == 2'd2, "R8 stall timeout", a_cap, 2);

    // R8: zero budget times out at once
    @(negedge clk);
    cfg_stall = 0; tmo_limit = 16'd0;
    mclr = 1; @(negedge clk); mclr = 0;
    start = 1; @(negedge clk); start = 0;
    for (int w = 0; w < 50 && a_dcnt == 0; w++) @(negedge clk);
    chk(a_cap == 2'd2, "R8 zero budget timeout", a_cap, 2);

    chk(!strap_bad, "R1 strap held through run", strap_bad, 0);
    finish_run();
  end
endmodule